// File: doc/BRIEF.md
# CCD Readout Pixel Region Tagger

This block follows the readout of a full-frame CCD. The clock sequencer drives it with a frame start, a line start and a pixel strobe, together with the digitized sample for each strobe. The block counts columns within the line and rows within the frame. For every strobed sample it gives a region tag, the row index and the column index. Because the serial-register geometry is fixed, the tag is a pure function of position. Every column count and row count is a parameter.

Each line opens with a few dummy shift phases. Light-shielded leading dark columns follow, and these act as the black reference. A single pass over them produces a per-line black level. The first few dark samples are skipped, and the remaining power-of-two count is summed and shifted down. The black level comes out with a one-cycle valid pulse, well ahead of the first active pixel, so downstream logic can subtract it. A line start that cuts a line short raises a sticky error flag.

The column phase is kept by a state machine with five states:
- IDLE: waits for the first frame start.
- DUMMY: covers the leading shift phases.
- DARK: covers the leading dark columns.
- BODY: covers buffer and active columns up to the nominal line length.
- HOVER: covers horizontal overclock beyond the nominal line length.

Its transitions are:
- IDLE to DUMMY, on a frame start.
- Any non-idle state back to DUMMY, on a frame start or line start (restart).
- DUMMY to DARK, on the strobe of the last dummy column.
- DARK to BODY, on the strobe of the last dark column.
- BODY to HOVER, on the strobe of the last nominal column.
- HOVER to HOVER, holding until the next restart.

Top module: `pixel_region_tagger`

## Requirements
- R1: For each accepted strobe, `pix_valid_o` is high in the following cycle, together with the tag, row and column of that sample. The tag codes are 0 dummy, 1 leading dark, 2 dark line, 3 buffer, 4 active and 5 overclock.
- R2: A frame start sets row 0 and column 0. A line start advances the row by one and sets column 0. Each accepted strobe advances the column. A strobe in the same cycle as either start is dropped. Strobes and line starts before the first frame start produce nothing.
- R3: Columns below DUMMY_CNT are tagged 0, and their samples never enter the black level.
- R4: The next DARK_CNT columns are tagged 1 in every row below TOTAL_ROWS.
- R5: In rows below TOP_DARK_ROWS, and in rows from TOTAL_ROWS-BOT_DARK_ROWS up to TOTAL_ROWS, every column from the dark end up to LINE_CNT is tagged 2.
- R6: Tag 4 is given when the column lies in the ACTIVE_COLS window that starts BUF_CNT columns after the dark columns, and the row lies in the ACTIVE_ROWS window that starts ROW_BUF rows after the top dark rows.
- R7: Any other column below LINE_CNT in a row below TOTAL_ROWS is tagged 3.
- R8: Columns at or above LINE_CNT are tagged 5, and so is every column of a row at or above TOTAL_ROWS.
- R9: The black level is the sum of the leading dark samples after the first DARK_DROP, shifted right by log2(DARK_CNT-DARK_DROP). `black_valid_o` pulses in the cycle that reports the last dark column, and only in rows below TOTAL_ROWS.
- R10: A line start that arrives while the column count is above 0 and below LINE_CNT sets `line_err_o`. The flag stays set until reset.
- R11: In reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_strobe | input | 1 | One sample present on `pix_data` |
| line_start | input | 1 | Begin the next row |
| frame_start | input | 1 | Begin row 0 of a new frame |
| pix_data | input | DATA_W | Digitized sample |
| tag_o | output | 3 | Region code of the reported sample |
| pix_valid_o | output | 1 | Tag, row and column are valid |
| row_o | output | ROW_W | Row index of the reported sample |
| col_o | output | COL_W | Column index of the reported sample |
| black_level_o | output | DATA_W | Per-line dark average |
| black_valid_o | output | 1 | One-cycle pulse when a new black level is ready |
| line_err_o | output | 1 | Sticky flag for a line cut short |

## Verification
The assertions check these relations on every cycle:
- A reported dummy tag always carries a column inside the dummy span.
- An active tag always lies inside both active windows.
- Any row past the frame is tagged overclock.
- The black-level pulse lines up with the report of the last dark column.
- The error flag never drops once it is set.

Only the bench scenarios can show the rest. These include the numeric value of the average with large values placed on the dummy columns, the row and column counting across frames and line restarts, and the dropping of strobes that collide with a start. They also include silence before the first frame start and the exact boundary at which a short line raises the error.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

    typedef enum logic [2:0] {
        TAG_DUMMY = 3'd0,
        TAG_LDARK = 3'd1,
        TAG_DLINE = 3'd2,
        TAG_BUF   = 3'd3,
        TAG_ACT   = 3'd4,
        TAG_OVER  = 3'd5
    } region_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DUMMY = 3'd1,
        ST_DARK  = 3'd2,
        ST_BODY  = 3'd3,
        ST_HOVER = 3'd4
    } colst_t;

endpackage

// File: rtl/ccd_col_fsm.sv
module ccd_col_fsm
    import ccd_tag_pkg::*;
#(
    parameter int COL_W     = 14,
    parameter int DUMMY_CNT = 20,
    parameter int DARK_CNT  = 36,
    parameter int LINE_CNT  = 4641
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             line_go,
    input  logic             frame_go,
    output colst_t           state,
    output logic [COL_W-1:0] col,
    output logic             restart,
    output logic             take,
    output logic             line_adv,
    output logic             short_line
);

    localparam logic [COL_W-1:0] C_DUMMY_LAST = COL_W'(DUMMY_CNT - 1);
    localparam logic [COL_W-1:0] C_DARK_LAST  = COL_W'(DUMMY_CNT + DARK_CNT - 1);
    localparam logic [COL_W-1:0] C_LINE_LAST  = COL_W'(LINE_CNT - 1);
    localparam logic [COL_W-1:0] C_LINE       = COL_W'(LINE_CNT);

    colst_t state_q, state_d;
    logic [COL_W-1:0] col_q;

    // outputs of the phase machine
    always_comb begin
        restart    = frame_go | (line_go && state_q != ST_IDLE);
        take       = strobe && !restart && state_q != ST_IDLE;
        line_adv   = line_go && !frame_go && state_q != ST_IDLE;
        short_line = line_adv && col_q != '0 && col_q < C_LINE;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_DUMMY;
        end else if (take) begin
            unique case (state_q)
                ST_DUMMY: if (col_q == C_DUMMY_LAST) state_d = ST_DARK;
                ST_DARK:  if (col_q == C_DARK_LAST)  state_d = ST_BODY;
                ST_BODY:  if (col_q == C_LINE_LAST)  state_d = ST_HOVER;
                ST_HOVER: state_d = ST_HOVER;
                default:  state_d = state_q;
            endcase
        end
    end

    // state register and column counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            if (restart)
                col_q <= '0;
            else if (take && col_q != '1)
                col_q <= col_q + 1'b1;
        end
    end

    assign state = state_q;
    assign col   = col_q;

endmodule

// File: rtl/ccd_row_track.sv
module ccd_row_track #(
    parameter int ROW_W         = 13,
    parameter int TOP_DARK_ROWS = 30,
    parameter int ROW_BUF       = 20,
    parameter int ACTIVE_ROWS   = 3600,
    parameter int TOTAL_ROWS    = 3695,
    parameter int BOT_DARK_ROWS = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_go,
    input  logic             line_adv,
    output logic [ROW_W-1:0] row,
    output logic             row_dark,
    output logic             row_active,
    output logic             row_over
);

    localparam logic [ROW_W-1:0] R_TOP    = ROW_W'(TOP_DARK_ROWS);
    localparam logic [ROW_W-1:0] R_ACT_LO = ROW_W'(TOP_DARK_ROWS + ROW_BUF);
    localparam logic [ROW_W-1:0] R_ACT_HI = ROW_W'(TOP_DARK_ROWS + ROW_BUF + ACTIVE_ROWS);
    localparam logic [ROW_W-1:0] R_BOT_LO = ROW_W'(TOTAL_ROWS - BOT_DARK_ROWS);
    localparam logic [ROW_W-1:0] R_TOTAL  = ROW_W'(TOTAL_ROWS);

    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (frame_go)
            row_q <= '0;
        else if (line_adv && row_q != '1)
            row_q <= row_q + 1'b1;
    end

    always_comb begin
        row_over   = row_q >= R_TOTAL;
        row_dark   = !row_over && (row_q < R_TOP || row_q >= R_BOT_LO);
        row_active = row_q >= R_ACT_LO && row_q < R_ACT_HI;
    end

    assign row = row_q;

endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg #(
    parameter int DATA_W    = 16,
    parameter int COL_W     = 14,
    parameter int DUMMY_CNT = 20,
    parameter int DARK_CNT  = 36,
    parameter int DARK_DROP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    input  logic              in_dark,
    input  logic              row_over,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] avg_o,
    output logic              avg_valid_o
);

    localparam int SHIFT = $clog2(DARK_CNT - DARK_DROP);
    localparam int ACC_W = DATA_W + $clog2(DARK_CNT) + 1;
    localparam logic [COL_W-1:0] C_KEEP_LO = COL_W'(DUMMY_CNT + DARK_DROP);
    localparam logic [COL_W-1:0] C_LAST    = COL_W'(DUMMY_CNT + DARK_CNT - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_c;
    logic             keep_c;

    always_comb begin
        keep_c = take && in_dark && col >= C_KEEP_LO;
        sum_c  = acc_q + {{(ACC_W-DATA_W){1'b0}}, data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            avg_o       <= '0;
            avg_valid_o <= 1'b0;
        end else begin
            avg_valid_o <= 1'b0;
            if (restart) begin
                acc_q <= '0;
            end else if (keep_c) begin
                acc_q <= sum_c;
                if (col == C_LAST) begin
                    avg_o       <= DATA_W'(sum_c >> SHIFT);
                    avg_valid_o <= !row_over;
                end
            end
        end
    end

endmodule

// File: rtl/pixel_region_tagger.sv
module pixel_region_tagger
    import ccd_tag_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int DUMMY_CNT     = 20,
    parameter int DARK_CNT      = 36,
    parameter int DARK_DROP     = 4,
    parameter int BUF_CNT       = 20,
    parameter int ACTIVE_COLS   = 4500,
    parameter int LINE_CNT      = 4641,
    parameter int TOP_DARK_ROWS = 30,
    parameter int ROW_BUF       = 20,
    parameter int ACTIVE_ROWS   = 3600,
    parameter int TOTAL_ROWS    = 3695,
    parameter int BOT_DARK_ROWS = 23,
    parameter int COL_W         = $clog2(LINE_CNT) + 1,
    parameter int ROW_W         = $clog2(TOTAL_ROWS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_strobe,
    input  logic              line_start,
    input  logic              frame_start,
    input  logic [DATA_W-1:0] pix_data,
    output logic [2:0]        tag_o,
    output logic              pix_valid_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DATA_W-1:0] black_level_o,
    output logic              black_valid_o,
    output logic              line_err_o
);

    localparam logic [COL_W-1:0] C_ACT_LO = COL_W'(DUMMY_CNT + DARK_CNT + BUF_CNT);
    localparam logic [COL_W-1:0] C_ACT_HI = COL_W'(DUMMY_CNT + DARK_CNT + BUF_CNT + ACTIVE_COLS);

    colst_t           state;
    logic [COL_W-1:0] col;
    logic             restart, take, line_adv, short_line;
    logic [ROW_W-1:0] row;
    logic             row_dark, row_active, row_over;
    region_t          tag_c;
    logic             col_act;

    ccd_col_fsm #(
        .COL_W(COL_W), .DUMMY_CNT(DUMMY_CNT), .DARK_CNT(DARK_CNT), .LINE_CNT(LINE_CNT)
    ) u_col (
        .clk(clk), .rst_n(rst_n), .strobe(pix_strobe), .line_go(line_start),
        .frame_go(frame_start), .state(state), .col(col), .restart(restart),
        .take(take), .line_adv(line_adv), .short_line(short_line)
    );

    ccd_row_track #(
        .ROW_W(ROW_W), .TOP_DARK_ROWS(TOP_DARK_ROWS), .ROW_BUF(ROW_BUF),
        .ACTIVE_ROWS(ACTIVE_ROWS), .TOTAL_ROWS(TOTAL_ROWS), .BOT_DARK_ROWS(BOT_DARK_ROWS)
    ) u_row (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_start), .line_adv(line_adv),
        .row(row), .row_dark(row_dark), .row_active(row_active), .row_over(row_over)
    );

    ccd_dark_avg #(
        .DATA_W(DATA_W), .COL_W(COL_W), .DUMMY_CNT(DUMMY_CNT),
        .DARK_CNT(DARK_CNT), .DARK_DROP(DARK_DROP)
    ) u_avg (
        .clk(clk), .rst_n(rst_n), .restart(restart), .take(take),
        .in_dark(state == ST_DARK), .row_over(row_over), .col(col), .data(pix_data),
        .avg_o(black_level_o), .avg_valid_o(black_valid_o)
    );

    // region decode of the sample being accepted
    always_comb begin
        col_act = col >= C_ACT_LO && col < C_ACT_HI;
        tag_c   = TAG_BUF;
        if (row_over) begin
            tag_c = TAG_OVER;
        end else begin
            unique case (state)
                ST_DUMMY: tag_c = TAG_DUMMY;
                ST_DARK:  tag_c = TAG_LDARK;
                ST_HOVER: tag_c = TAG_OVER;
                ST_BODY: begin
                    if (row_dark)                tag_c = TAG_DLINE;
                    else if (row_active && col_act) tag_c = TAG_ACT;
                    else                         tag_c = TAG_BUF;
                end
                default:  tag_c = TAG_BUF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o       <= '0;
            pix_valid_o <= 1'b0;
            row_o       <= '0;
            col_o       <= '0;
            line_err_o  <= 1'b0;
        end else begin
            pix_valid_o <= take;
            if (take) begin
                tag_o <= tag_c;
                row_o <= row;
                col_o <= col;
            end
            if (short_line)
                line_err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pixel_region_tagger_chk.sv
module pixel_region_tagger_chk #(
    parameter int COL_W         = 14,
    parameter int ROW_W         = 13,
    parameter int DUMMY_CNT     = 20,
    parameter int DARK_CNT      = 36,
    parameter int BUF_CNT       = 20,
    parameter int ACTIVE_COLS   = 4500,
    parameter int TOP_DARK_ROWS = 30,
    parameter int ROW_BUF       = 20,
    parameter int ACTIVE_ROWS   = 3600,
    parameter int TOTAL_ROWS    = 3695
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       tag_o,
    input logic             pix_valid_o,
    input logic [ROW_W-1:0] row_o,
    input logic [COL_W-1:0] col_o,
    input logic             black_valid_o,
    input logic             line_err_o
);

    localparam logic [COL_W-1:0] K_DUMMY  = COL_W'(DUMMY_CNT);
    localparam logic [COL_W-1:0] K_DLAST  = COL_W'(DUMMY_CNT + DARK_CNT - 1);
    localparam logic [COL_W-1:0] K_ACT_LO = COL_W'(DUMMY_CNT + DARK_CNT + BUF_CNT);
    localparam logic [COL_W-1:0] K_ACT_HI = COL_W'(DUMMY_CNT + DARK_CNT + BUF_CNT + ACTIVE_COLS);
    localparam logic [ROW_W-1:0] K_R_LO   = ROW_W'(TOP_DARK_ROWS + ROW_BUF);
    localparam logic [ROW_W-1:0] K_R_HI   = ROW_W'(TOP_DARK_ROWS + ROW_BUF + ACTIVE_ROWS);
    localparam logic [ROW_W-1:0] K_TOTAL  = ROW_W'(TOTAL_ROWS);

    AST_TAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> tag_o <= 3'd5); // R1

    AST_DUMMY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && tag_o == 3'd0) |-> col_o < K_DUMMY); // R3

    AST_ACTIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && tag_o == 3'd4) |->
        (col_o >= K_ACT_LO && col_o < K_ACT_HI && row_o >= K_R_LO && row_o < K_R_HI)); // R6

    AST_ROW_OVERCLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && row_o >= K_TOTAL) |-> tag_o == 3'd5); // R8

    AST_BLACK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        black_valid_o |-> (pix_valid_o && tag_o == 3'd1 && col_o == K_DLAST)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        line_err_o |=> line_err_o); // R10

endmodule

bind pixel_region_tagger pixel_region_tagger_chk #(
    .COL_W(COL_W), .ROW_W(ROW_W), .DUMMY_CNT(DUMMY_CNT), .DARK_CNT(DARK_CNT),
    .BUF_CNT(BUF_CNT), .ACTIVE_COLS(ACTIVE_COLS), .TOP_DARK_ROWS(TOP_DARK_ROWS),
    .ROW_BUF(ROW_BUF), .ACTIVE_ROWS(ACTIVE_ROWS), .TOTAL_ROWS(TOTAL_ROWS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tag_o(tag_o), .pix_valid_o(pix_valid_o),
    .row_o(row_o), .col_o(col_o), .black_valid_o(black_valid_o), .line_err_o(line_err_o)
);

// File: tb/pixel_region_tagger_test.sv
`timescale 1ns/1ps
module pixel_region_tagger_test;

    localparam int DW = 12, DU = 3, DK = 6, DR = 2, BF = 2, AC = 5, LC = 20;
    localparam int TD = 2, RB = 1, AR = 3, TR = 9, BD = 1;
    localparam int CW = 6, RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_strobe = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic [2:0] tag_o;
    logic pix_valid_o, black_valid_o, line_err_o;
    logic [RW-1:0] row_o;
    logic [CW-1:0] col_o;
    logic [DW-1:0] black_level_o;

    always #4 clk = ~clk;

    pixel_region_tagger #(
        .DATA_W(DW), .DUMMY_CNT(DU), .DARK_CNT(DK), .DARK_DROP(DR), .BUF_CNT(BF),
        .ACTIVE_COLS(AC), .LINE_CNT(LC), .TOP_DARK_ROWS(TD), .ROW_BUF(RB),
        .ACTIVE_ROWS(AR), .TOTAL_ROWS(TR), .BOT_DARK_ROWS(BD), .COL_W(CW), .ROW_W(RW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pix_strobe(pix_strobe), .line_start(line_start),
        .frame_start(frame_start), .pix_data(pix_data), .tag_o(tag_o),
        .pix_valid_o(pix_valid_o), .row_o(row_o), .col_o(col_o),
        .black_level_o(black_level_o), .black_valid_o(black_valid_o), .line_err_o(line_err_o)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    int  m_row = 0, m_col = 0, m_acc = 0;
    bit  m_armed = 0, m_err = 0;
    bit  e_pv, e_bv;
    int  e_tag, e_row, e_col, e_bl;

    function automatic int ref_tag(int r, int c);
        if (r >= TR || c >= LC) return 5;        // R8
        if (c < DU) return 0;                    // R3
        if (c < DU + DK) return 1;               // R4
        if (r < TD || r >= TR - BD) return 2;    // R5
        if (r >= TD + RB && r < TD + RB + AR && c >= DU + DK + BF && c < DU + DK + BF + AC)
            return 4;                            // R6
        return 3;                                // R7
    endfunction

    function automatic string tag_req(int t);
        case (t)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R7";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic step(input bit fs, input bit ls, input bit st, input int d);
        frame_start = fs; line_start = ls; pix_strobe = st; pix_data = DW'(d);
        e_pv = 0; e_bv = 0;
        if (fs) begin
            m_armed = 1; m_row = 0; m_col = 0; m_acc = 0;
        end else if (ls && m_armed) begin
            if (m_col > 0 && m_col < LC) m_err = 1;
            m_row++; m_col = 0; m_acc = 0;
        end else if (st && m_armed) begin
            e_pv = 1; e_tag = ref_tag(m_row, m_col); e_row = m_row; e_col = m_col;
            if (m_col >= DU + DR && m_col < DU + DK) m_acc += d;
            if (m_col == DU + DK - 1 && m_row < TR) begin
                e_bv = 1; e_bl = m_acc >> $clog2(DK - DR);
            end
            m_col++;
        end
        @(negedge clk);
        chk(pix_valid_o == e_pv, "R1", "pix_valid", int'(pix_valid_o), int'(e_pv));
        if (e_pv && pix_valid_o) begin
            chk(int'(tag_o) == e_tag, tag_req(e_tag), "tag", int'(tag_o), e_tag);
            chk(int'(row_o) == e_row, "R2", "row", int'(row_o), e_row);
            chk(int'(col_o) == e_col, "R2", "col", int'(col_o), e_col);
        end
        chk(black_valid_o == e_bv, "R9", "black_valid", int'(black_valid_o), int'(e_bv));
        if (e_bv && black_valid_o)
            chk(int'(black_level_o) == e_bl, "R9", "black_level", int'(black_level_o), e_bl);
        chk(line_err_o == m_err, "R10", "line_err", int'(line_err_o), int'(m_err));
    endtask

    function automatic int pd(int r, int c);
        if (c < DU) return 4095;  // large dummy values must not leak into R3 average
        return ((r * 53 + c * 29) % 1000) + 100;
    endfunction

    task automatic run_line(input int r, input int n);
        for (int c = 0; c < n; c++) begin
            step(0, 0, 1, pd(r, c));
            if (c % 7 == 6) step(0, 0, 0, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(pix_valid_o == 0, "R11", "reset pix_valid", int'(pix_valid_o), 0);
        chk(black_valid_o == 0, "R11", "reset black_valid", int'(black_valid_o), 0);
        chk(line_err_o == 0, "R11", "reset line_err", int'(line_err_o), 0);
        chk(tag_o == 0 && row_o == 0 && col_o == 0, "R11", "reset tag/row/col", int'(tag_o), 0);
        rst_n = 1'b1;
        // R2 activity before first frame start is ignored
        step(0, 0, 1, 7); step(0, 1, 0, 0); step(0, 0, 1, 9); step(0, 0, 0, 0);
        // full frame with horizontal and vertical overclock
        step(1, 0, 0, 0);
        for (int r = 0; r < TR + 2; r++) begin
            run_line(r, LC + 2);
            step(0, 1, 0, 0);
        end
        // R10 line start with zero columns: no error
        step(0, 1, 0, 0);
        // R2 strobe colliding with a line start is dropped
        step(1, 0, 0, 0);
        run_line(0, LC);
        step(0, 1, 1, 55);
        run_line(1, 4);
        // R10 short line raises the sticky flag
        step(0, 1, 0, 0);
        run_line(2, 3);
        step(1, 0, 1, 77);   // R2 frame start with strobe: strobe dropped
        run_line(0, LC + 1);
        repeat (4) step(0, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule